// File: doc/BRIEF.md
# I2C Bus-Clear Recovery Sequencer

This block clears an I2C bus that a target device holds stuck, which happens when the controller is reset halfway through an acknowledge and the target keeps the data line low. It runs before the normal I2C controller is let out of reset. The block releases SDA and watches it. While SDA reads low, it pulses SCL through an open-drain enable. It stops as soon as SDA reads high, and it gives up after a bounded number of pulses.

When SDA comes back after one or more pulses, the block places a STOP condition on the bus. This returns the target's state machine to idle. It then reports success, or failure if it gave up. Each of its outputs is an open-drain pull-down enable: 1 pulls the line low and 0 releases it to the external pull-up. A hold output keeps the following controller in reset from power-on until the sequence has ended. The half-period of every generated phase is programmable. It is never made shorter than the timing that the `CLK_KHZ` parameter yields for a 100 kHz bus.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset the block is idle. scl_oe, sda_oe, busy, done, ok and fail are 0, and mst_hold is 1.
- R2: If the synchronized SDA reads high when a start is accepted, no SCL pulse is issued. done and ok are then 1 two cycles after the cycle in which start was sampled.
- R3: A start is accepted only while idle, and it latches H = max(half_div, ceil(CLK_KHZ/200)). Each pulse drives scl_oe high for exactly H cycles. The pulse ends after H further cycles in which the two-flop-synchronized SCL reads high.
- R4: After each pulse, synchronized SDA is sampled. If it is high and at least one pulse was issued, the block does three things in order. It asserts sda_oe for H cycles with scl_oe at 0. It releases sda_oe for H cycles. It then signals done with ok.
- R5: After MAX_PULSES+1 pulses (101 by default) the block stops and signals done with fail, and it issues no STOP. At that check, the limit takes priority over SDA reading high.
- R6: sda_oe is asserted only during the STOP phase and never in the same cycle as scl_oe.
- R7: done is a one-cycle pulse that comes with exactly one of ok or fail set. Those two flags hold their value until the next accepted start clears them.
- R8: mst_hold is 1 from reset and throughout a run. It drops to 0 in the cycle done is asserted and stays 0 until the next accepted start.
- R9: A start while busy has no effect on the run. Only one done pulse follows, and the pulse count is unchanged.
- R10: Changing half_div during a run does not change the phase lengths of that run.
- R11: While the synchronized SCL reads low after a release (clock stretching), the high-phase count pauses. The next pulse is delayed accordingly.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a recovery run (accepted only while idle) |
| half_div | input | HALF_W | Requested half-period in clock cycles |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | SCL pull-down enable (1 = drive low) |
| sda_oe | output | 1 | SDA pull-down enable (1 = drive low) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| ok | output | 1 | Last run freed the bus |
| fail | output | 1 | Last run reached the pulse limit |
| mst_hold | output | 1 | Keeps the following I2C controller in reset |

## Verification
Two decisions can fall on the same post-pulse check: the target releasing SDA, and the pulse limit being reached. The bench makes the modelled target let go on the limit pulse itself, and expects fail with no STOP. It then lets go one pulse earlier and expects ok after exactly 100 pulses and a STOP. A second collision is a new start in the cycle that done is high. This must be accepted and must clear the flags, and the bench compares it cycle by cycle against its reference model.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;

  typedef enum logic [2:0] {
    BC_IDLE,
    BC_CHECK,
    BC_LOW,
    BC_HIGH,
    BC_STOP_LO,
    BC_STOP_REL
  } bc_state_e;

  // shortest legal half-period for a 100 kHz bus, from the clock in kHz
  function automatic int unsigned bc_half_floor(input int unsigned clk_khz);
    int unsigned v;
    v = (clk_khz + 199) / 200;
    return (v == 0) ? 1 : v;
  endfunction

  // half-period actually used: the request, raised to the floor
  function automatic int unsigned bc_eff_half(input int unsigned req,
                                              input int unsigned floor_v);
    return (req < floor_v) ? floor_v : req;
  endfunction

endpackage

// File: rtl/bc_sync.sv
module bc_sync #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= d[i];
        s2 <= s1;
      end
    end
    assign q[i] = s2;
  end
endmodule

// File: rtl/bc_half_timer.sv
module bc_half_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] limit,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (cnt == limit - W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr || hit)  cnt <= '0;
    else if (en)          cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/bc_pulse_ctr.sv
module bc_pulse_ctr #(
  parameter int MAXP = 100,
  localparam int CW  = $clog2(MAXP + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] count,
  output logic          over
);
  assign over = count > CW'(MAXP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + CW'(1);
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int HALF_W     = 16,
  parameter int MAX_PULSES = 100,
  parameter int CLK_KHZ    = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [HALF_W-1:0] half_div,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              done,
  output logic              ok,
  output logic              fail,
  output logic              mst_hold
);
  localparam int unsigned FLOOR_RAW = bc_half_floor(CLK_KHZ);
  localparam int          CW        = $clog2(MAX_PULSES + 2);

  bc_state_e state, nxt;

  // named internal events
  logic              scl_s, sda_s;
  logic              start_acc;
  logic              tmr_hit, tmr_en, tmr_clr;
  logic              pulse_done;
  logic              pulse_over;
  logic [CW-1:0]     pulse_cnt;
  logic [HALF_W-1:0] half_q;
  logic              finish_ok, finish_fail;

  bc_sync #(.W(2)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    ({scl_i, sda_i}),
    .q    ({scl_s, sda_s})
  );

  assign start_acc = start && (state == BC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         half_q <= HALF_W'(FLOOR_RAW);
    else if (start_acc) half_q <= HALF_W'(bc_eff_half(32'(half_div), FLOOR_RAW));
  end

  always_comb begin
    tmr_en = 1'b0;
    unique case (state)
      BC_LOW, BC_STOP_LO, BC_STOP_REL: tmr_en = 1'b1;
      BC_HIGH:                         tmr_en = scl_s;
      default:                         tmr_en = 1'b0;
    endcase
  end
  assign tmr_clr = (state == BC_IDLE) || (state == BC_CHECK);

  bc_half_timer #(.W(HALF_W)) u_timer (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (tmr_clr),
    .en   (tmr_en),
    .limit(half_q),
    .hit  (tmr_hit)
  );

  assign pulse_done = (state == BC_HIGH) && tmr_hit;

  bc_pulse_ctr #(.MAXP(MAX_PULSES)) u_pulses (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (start_acc),
    .inc  (pulse_done),
    .count(pulse_cnt),
    .over (pulse_over)
  );

  assign finish_fail = (state == BC_CHECK) && pulse_over;
  assign finish_ok   = ((state == BC_CHECK) && !pulse_over && sda_s && (pulse_cnt == '0))
                     || ((state == BC_STOP_REL) && tmr_hit);

  always_comb begin
    nxt = state;
    unique case (state)
      BC_IDLE:     if (start) nxt = BC_CHECK;
      BC_CHECK: begin
        if (pulse_over)            nxt = BC_IDLE;
        else if (!sda_s)           nxt = BC_LOW;
        else if (pulse_cnt == '0)  nxt = BC_IDLE;
        else                       nxt = BC_STOP_LO;
      end
      BC_LOW:      if (tmr_hit) nxt = BC_HIGH;
      BC_HIGH:     if (tmr_hit) nxt = BC_CHECK;
      BC_STOP_LO:  if (tmr_hit) nxt = BC_STOP_REL;
      BC_STOP_REL: if (tmr_hit) nxt = BC_IDLE;
      default:     nxt = BC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= BC_IDLE;
    else        state <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      ok       <= 1'b0;
      fail     <= 1'b0;
      mst_hold <= 1'b1;
    end else begin
      done <= finish_ok || finish_fail;
      if (start_acc) begin
        ok       <= 1'b0;
        fail     <= 1'b0;
        mst_hold <= 1'b1;
      end
      if (finish_ok)   ok   <= 1'b1;
      if (finish_fail) fail <= 1'b1;
      if (finish_ok || finish_fail) mst_hold <= 1'b0;
    end
  end

  assign scl_oe = (state == BC_LOW);
  assign sda_oe = (state == BC_STOP_LO);
  assign busy   = (state != BC_IDLE);

endmodule

// File: rtl/bc_checker.sv
module bc_checker #(
  parameter int HALF_W     = 16,
  parameter int CW         = 7,
  parameter int MAX_PULSES = 100
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_oe,
  input logic              sda_oe,
  input logic              busy,
  input logic              done,
  input logic              ok,
  input logic              fail,
  input logic              mst_hold,
  input logic [CW-1:0]     pulse_cnt,
  input logic [HALF_W-1:0] half_q
);
  logic [HALF_W:0] low_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      low_len <= '0;
    else if (scl_oe) low_len <= low_len + 1'b1;
    else             low_len <= '0;
  end

  AST_SDA_NOT_WITH_SCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sda_oe && scl_oe)); // R6

  AST_STOP_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe) |-> !scl_oe); // R4

  AST_SCL_LOW_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> (low_len == {1'b0, half_q})); // R3

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_DONE_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (ok != fail)); // R7

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> mst_hold); // R8

  AST_RELEASE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mst_hold); // R8

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= CW'(MAX_PULSES + 1)); // R5

endmodule

bind i2c_bus_clear bc_checker #(
  .HALF_W    (HALF_W),
  .CW        (CW),
  .MAX_PULSES(MAX_PULSES)
) u_bc_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .busy     (busy),
  .done     (done),
  .ok       (ok),
  .fail     (fail),
  .mst_hold (mst_hold),
  .pulse_cnt(pulse_cnt),
  .half_q   (half_q)
);

// File: tb/tb_i2c_bus_clear.sv
module tb_i2c_bus_clear;
  localparam int CLK_PERIOD = 10;
  localparam int HW         = 8;
  localparam int MAXP       = 100;
  localparam int KHZ        = 800;
  localparam int FLOOR      = 4;   // ceil(800/200)

  localparam int P_IDLE = 0, P_CHK = 1, P_LOW = 2, P_HIGH = 3, P_SLO = 4, P_SREL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [HW-1:0] half_div = 8'd6;
  logic scl_i, sda_i, scl_oe, sda_oe, busy, done, ok, fail, mst_hold;

  // environment: target device and stretching
  bit slave_arm = 1'b0;
  int rel_after = 0;
  int edges = 0;
  bit slave_hold = 1'b0;
  int stretch_cfg = 0;
  int stretch_left = 0;
  bit stretch_on = 1'b0;
  bit scl_prev = 1'b1;

  assign scl_i = !scl_oe && !stretch_on;
  assign sda_i = !sda_oe && !slave_hold;

  i2c_bus_clear #(.HALF_W(HW), .MAX_PULSES(MAXP), .CLK_KHZ(KHZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .half_div(half_div),
    .scl_i(scl_i), .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .busy(busy), .done(done), .ok(ok), .fail(fail), .mst_hold(mst_hold));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_tests = 0;
  int n_fail = 0;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    n_tests++;
    if (!cond) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // reference model
  int m_ph, m_t, m_p, m_h;
  bit m_ok, m_fail, m_done, m_hold;
  bit m_sda1, m_sda2, m_scl1, m_scl2;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = P_IDLE; m_t = 0; m_p = 0; m_h = FLOOR;
      m_ok = 0; m_fail = 0; m_done = 0; m_hold = 1;
      m_sda1 = 1; m_sda2 = 1; m_scl1 = 1; m_scl2 = 1;
    end else begin
      m_done = 0;
      case (m_ph)
        P_IDLE: if (start) begin
          m_ph = P_CHK; m_p = 0; m_ok = 0; m_fail = 0; m_hold = 1;
          m_h = (int'(half_div) < FLOOR) ? FLOOR : int'(half_div);
        end
        P_CHK: begin
          m_t = 0;
          if (m_p > MAXP) begin m_fail = 1; m_done = 1; m_hold = 0; m_ph = P_IDLE; end
          else if (m_sda2 && m_p == 0) begin m_ok = 1; m_done = 1; m_hold = 0; m_ph = P_IDLE; end
          else if (m_sda2) m_ph = P_SLO;
          else m_ph = P_LOW;
        end
        P_LOW: if (m_t == m_h - 1) begin m_t = 0; m_ph = P_HIGH; end else m_t++;
        P_HIGH: if (m_scl2) begin
          if (m_t == m_h - 1) begin m_t = 0; m_p++; m_ph = P_CHK; end else m_t++;
        end
        P_SLO: if (m_t == m_h - 1) begin m_t = 0; m_ph = P_SREL; end else m_t++;
        P_SREL: if (m_t == m_h - 1) begin
          m_t = 0; m_ok = 1; m_done = 1; m_hold = 0; m_ph = P_IDLE;
        end else m_t++;
        default: m_ph = P_IDLE;
      endcase
      m_sda2 = m_sda1; m_sda1 = sda_i;
      m_scl2 = m_scl1; m_scl1 = scl_i;
    end
  end

  // monitors
  int pulses_seen = 0;
  int stop_cycles = 0;
  int done_count = 0;
  int low_run = 0;
  int last_low = 0;
  bit scl_oe_prev = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      check(scl_oe == (m_ph == P_LOW), "R3 R11 scl_oe", scl_oe, m_ph == P_LOW);
      check(sda_oe == (m_ph == P_SLO), "R4 R6 sda_oe", sda_oe, m_ph == P_SLO);
      check(busy == (m_ph != P_IDLE), "R9 busy", busy, m_ph != P_IDLE);
      check(done == m_done, "R7 done", done, m_done);
      check(ok == m_ok, "R4 ok", ok, m_ok);
      check(fail == m_fail, "R5 fail", fail, m_fail);
      check(mst_hold == m_hold, "R8 mst_hold", mst_hold, m_hold);
      if (scl_oe && !scl_oe_prev) pulses_seen++;
      if (scl_oe) low_run++;
      else begin
        if (scl_oe_prev) last_low = low_run;
        low_run = 0;
      end
      scl_oe_prev = scl_oe;
      if (sda_oe) stop_cycles++;
      if (done) done_count++;
    end
    // target device and stretch model
    if (scl_i && !scl_prev) edges++;
    scl_prev = scl_i;
    slave_hold = slave_arm && (edges < rel_after);
    if (scl_oe) stretch_left = stretch_cfg;
    else if (stretch_left > 0) stretch_left--;
    stretch_on = (stretch_left > 0);
  end

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic wait_done();
    int lim = 0;
    do begin @(negedge clk); lim++; end while (!done && lim < 5000);
  endtask

  task automatic setup(input bit arm, input int rel, input int str, input int half);
    @(negedge clk);
    slave_arm = arm; rel_after = rel; edges = 0; stretch_cfg = str;
    half_div = HW'(half);
    slave_hold = arm && (rel > 0);
    repeat (4) @(negedge clk);
    pulses_seen = 0; stop_cycles = 0; done_count = 0;
  endtask

  task automatic go();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic expect_end(input string tag, input bit exp_ok, input int exp_p,
                            input int exp_stop);
    check(ok == exp_ok, {tag, " ok"}, ok, exp_ok);
    check(fail == !exp_ok, {tag, " fail"}, fail, !exp_ok);
    check(pulses_seen == exp_p, {tag, " pulses"}, pulses_seen, exp_p);
    check(stop_cycles == exp_stop, {tag, " stop length"}, stop_cycles, exp_stop);
    check(mst_hold == 1'b0, {tag, " R8 handover"}, mst_hold, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(scl_oe == 0 && sda_oe == 0, "R1 pins released", {scl_oe, sda_oe}, 0);
    check(busy == 0 && done == 0, "R1 idle", {busy, done}, 0);
    check(ok == 0 && fail == 0, "R1 flags", {ok, fail}, 0);
    check(mst_hold == 1, "R1 hold", mst_hold, 1);
    rst_n = 1'b1;

    // R2 bus already free: done two cycles after start is sampled
    setup(0, 0, 0, 6);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(done == 0, "R2 no early done", done, 0);
    @(negedge clk);
    check(done == 1, "R2 done latency", done, 1);
    expect_end("R2", 1, 0, 0);

    // R4 release after 3 pulses, STOP of length H
    setup(1, 3, 0, 5);
    go(); wait_done();
    expect_end("R4", 1, 3, 5);
    check(last_low == 5, "R3 low width", last_low, 5);
    check(ok == 1, "R7 flag holds", ok, 1);
    repeat (3) @(negedge clk);
    check(ok == 1 && done == 0, "R7 flag held after done", ok, 1);

    // R5 never released
    setup(1, 100000, 0, 4);
    go(); wait_done();
    expect_end("R5 stuck", 0, MAXP + 1, 0);

    // R5 release on the limit pulse: limit wins
    setup(1, MAXP + 1, 0, 4);
    go(); wait_done();
    expect_end("R5 collide", 0, MAXP + 1, 0);

    // R5 release one pulse earlier: success
    setup(1, MAXP, 0, 4);
    go(); wait_done();
    expect_end("R5 last ok", 1, MAXP, 4);

    // R3 floor applies to short request
    setup(1, 2, 0, 2);
    go(); wait_done();
    expect_end("R3 floor", 1, 2, FLOOR);
    check(last_low == FLOOR, "R3 floor width", last_low, FLOOR);

    // R11 stretching
    setup(1, 2, 6, 4);
    go(); wait_done();
    expect_end("R11", 1, 2, 4);

    // R9 / R10: start and half change during a run
    setup(1, 4, 0, 5);
    go();
    repeat (10) @(negedge clk);
    start = 1'b1; half_div = 8'd9;
    @(negedge clk); start = 1'b0;
    wait_done();
    expect_end("R9", 1, 4, 5);
    check(last_low == 5, "R10 half unchanged", last_low, 5);
    repeat (3) @(negedge clk);
    check(done_count == 1, "R9 single done", done_count, 1);

    // start in the done cycle is accepted
    setup(1, 1, 0, 4);
    go(); wait_done();
    slave_arm = 0; slave_hold = 0;
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(ok == 0 && busy == 1, "R7 flags cleared on accept", ok, 0);
    @(negedge clk);
    check(done == 1 && ok == 1, "R2 restart done", done, 1);

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule